// File: doc/BRIEF.md
# NRZ to Manchester Line Encoder

This block turns a serial NRZ bit stream into a Manchester-coded line signal. It is clocked at twice the bit rate, and every NRZ bit is held on the input for two consecutive fast-clock cycles. Each bit therefore spans two half-bit cells. The output holds one level in the first cell and the opposite level in the second, so the line changes level in the middle of every bit. A zero bit is sent low-then-high and a one bit is sent high-then-low.

The encoder is a four-state Moore machine. The output is taken directly from a flip-flop, so it carries no combinational hazards when the input moves between clock edges. The cost is one fast-clock cycle of latency. Releasing the synchronous reset aligns the encoder to the bit grid: the first rising edge after reset is taken as the start of a bit. The input is then sampled only at bit-start edges, and its value at the mid-bit edge has no effect.

Top module: `nrz_manchester_enc`

## Requirements
- R1: While `rst` is high at a rising edge, `manch_out` is 0 after that edge, whatever `nrz_in` is.
- R2: A bit of value 0 appears on `manch_out` as 0 for one cycle, then 1 for one cycle.
- R3: A bit of value 1 appears on `manch_out` as 1 for one cycle, then 0 for one cycle.
- R4: The first-cell level of a bit is visible on `manch_out` directly after the rising edge that samples the bit. That edge is the first edge after reset release, and then every second edge.
- R5: `manch_out` always changes level at the mid-bit edge, including across runs of equal bits and across alternating bits.
- R6: The value of `nrz_in` at a mid-bit edge is ignored. Flipping it for the second cycle of a bit leaves both cells of that bit, and the alignment of the following bits, unchanged.
- R7: A reset asserted part-way through a bit forces `manch_out` to 0 at the next edge. After release, the first edge begins a fresh bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset; its release marks a bit start |
| nrz_in | input | 1 | Serial NRZ data, held for two clock cycles per bit |
| manch_out | output | 1 | Registered Manchester line output |

## Verification
The first-cell level of a bit is due right after the edge that samples the bit. The second-cell level is due one edge later, and a reset takes effect at the first edge at which it is high. The driver presents each bit at a falling edge and queues the two cell levels. The monitor pops one queued level two nanoseconds after each rising edge, so each comparison lands in the cycle the result is due. Inputs are driven only on falling edges, and reset is released just after a rising edge. This keeps bit alignment fixed, so the bench can also flip the input in the second cycle of a bit without changing any expected value.

// File: rtl/mnc_pkg.sv
package mnc_pkg;

  // Encoder state: line level currently driven, and whether the next edge
  // is the mid-bit edge (first cell now showing).
  typedef struct packed {
    logic level;
    logic first_cell;
  } mnc_state_t;

  localparam int unsigned STATE_W = $bits(mnc_state_t);

  // Idle / post-reset state: line low, next edge starts a bit.
  localparam mnc_state_t ST_IDLE = '{level: 1'b0, first_cell: 1'b0};

endpackage

// File: rtl/mnc_next_state.sv
module mnc_next_state
  import mnc_pkg::*;
(
  input  mnc_state_t cur,
  input  logic       data_bit,
  output mnc_state_t nxt
);

  // At a bit-start edge the first cell takes the data value.
  // At the mid-bit edge the line inverts and the input is not looked at.
  always_comb begin
    if (cur.first_cell) begin
      nxt.level      = ~cur.level;
      nxt.first_cell = 1'b0;
    end else begin
      nxt.level      = data_bit;
      nxt.first_cell = 1'b1;
    end
  end

endmodule

// File: rtl/mnc_state_reg.sv
module mnc_state_reg
  import mnc_pkg::*;
#(
  parameter mnc_state_t RESET_STATE = ST_IDLE
) (
  input  logic       clk,
  input  logic       rst,
  input  mnc_state_t d,
  output mnc_state_t q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_STATE;
    else     q <= d;
  end

endmodule

// File: rtl/nrz_manchester_enc.sv
module nrz_manchester_enc
  import mnc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nrz_in,
  output logic manch_out
);

  mnc_state_t state_q;
  mnc_state_t state_d;
  logic       first_cell_q;

  mnc_next_state u_next (
    .cur      (state_q),
    .data_bit (nrz_in),
    .nxt      (state_d)
  );

  mnc_state_reg #(.RESET_STATE(ST_IDLE)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  assign first_cell_q = state_q.first_cell;
  assign manch_out    = state_q.level;

endmodule

// File: rtl/nrz_manchester_enc_chk.sv
module nrz_manchester_enc_chk (
  input logic clk,
  input logic rst,
  input logic nrz_in,
  input logic manch_out,
  input logic first_cell
);

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !manch_out);

  // R4
  first_cell_level_chk: assert property (@(posedge clk) disable iff (rst)
    !first_cell |=> (manch_out == $past(nrz_in)));

  // R5
  mid_bit_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    first_cell |=> (manch_out != $past(manch_out)));

  // R6
  mid_edge_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    first_cell |=> !first_cell);

  // R7
  reset_realign_chk: assert property (@(posedge clk)
    rst |=> !first_cell);

endmodule

bind nrz_manchester_enc nrz_manchester_enc_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .nrz_in     (nrz_in),
  .manch_out  (manch_out),
  .first_cell (first_cell_q)
);

// File: tb/nrz_manchester_enc_tb.sv
`timescale 1ns/1ps
module nrz_manchester_enc_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz_in = 1'b0;
  logic manch_out;

  typedef struct {
    logic  lvl;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #4 clk = ~clk;

  nrz_manchester_enc dut_i (
    .clk       (clk),
    .rst       (rst),
    .nrz_in    (nrz_in),
    .manch_out (manch_out)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: manch_out=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic push(input logic lvl, input string tag);
    exp_t e;
    e.lvl = lvl;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: one expected cell per rising edge, sampled after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(manch_out, e.lvl, e.tag);
      end
    end
  end

  // One bit: first cell (R2/R3 or caller tag), then mid-bit cell (R5, or R6 when flipped).
  task automatic send_bit(input logic b, input logic flip_mid, input string tag);
    @(negedge clk);
    nrz_in = b;
    push(b, (tag != "") ? tag : (b ? "R3" : "R2"));
    @(negedge clk);
    nrz_in = flip_mid ? ~b : b;
    push(~b, flip_mid ? "R6" : "R5");
  endtask

  // Hold reset for n edges checking a low line, then release just after an edge.
  task automatic do_reset(input int n, input string tag);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      nrz_in = i[0];
      @(posedge clk);
      #2;
      check(manch_out, 1'b0, tag);
    end
    rst = 1'b0;
  endtask

  initial begin
    logic [15:0] lfsr;
    do_reset(4, "R1");
    // R4: first bit after release shows up right after the first edge
    send_bit(1'b1, 1'b0, "R4");
    send_bit(1'b0, 1'b0, "");
    for (int i = 0; i < 6; i++) send_bit(i[0], 1'b0, "");   // alternating
    for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0, "");   // run of zeros
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, "");   // run of ones
    send_bit(1'b0, 1'b0, ""); send_bit(1'b0, 1'b0, "");
    send_bit(1'b1, 1'b0, ""); send_bit(1'b1, 1'b0, "");
    // R6: input flipped during the mid-bit cycle
    for (int i = 0; i < 8; i++) send_bit(i[1], 1'b1, "");
    send_bit(1'b1, 1'b0, ""); send_bit(1'b0, 1'b0, "");
    // Pseudo-random stream, every third bit with a flipped mid-bit input
    lfsr = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      send_bit(lfsr[0], (i % 3) == 0, "");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    // R7: reset part-way through a bit (after the first cell of a 1)
    @(negedge clk);
    nrz_in = 1'b1;
    push(1'b1, "R7");
    do_reset(2, "R7");
    send_bit(1'b0, 1'b0, "R7");
    send_bit(1'b1, 1'b0, "");
    send_bit(1'b1, 1'b1, "");
    send_bit(1'b0, 1'b0, "");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule